// File: doc/BRIEF.md
# Multi-Enable Interrupt Pending Aggregator

This block watches a fixed set of level-sensitive interrupt sources and raises one interrupt request line to the CPU. A source becomes eligible only after a configurable number of independent enable points has switched it on. Each enable point sends a one-cycle increment strobe when it turns on and a one-cycle decrement strobe when it turns off. A source is pending while its level is high and all of its enable points agree.

The block counts the pending sources. The CPU request line is high whenever that count is non-zero. A vector-fetch port lets the CPU ask for the code of the pending source with the lowest index. The request is refused when the CPU's 4-bit interrupt mask is all ones, and it is also refused when no source is pending.

Top module: `irq_pend_agg`

## Requirements
- R1: After reset, every enable count is zero, no source is pending, `cpu_irq` is low and `vec_valid` is low.
- R2: Each source has an enable count that moves up on `en_inc[i]` and down on `en_dec[i]`. The count never goes above that source's ceiling in `EN_MAX` (bits `[i*CNT_W +: CNT_W]`) and never goes below zero. A source counts as enabled only when its count equals its ceiling. A source whose ceiling is 0 is never enabled.
- R3: A source is pending from the clock edge that samples both a high `src_level[i]` and a full enable count. It stops being pending at the edge that samples either condition gone.
- R4: Holding `src_level[i]` at a constant value does not change the source's state. Only a change of level moves the source's asserted state.
- R5: `cpu_irq` becomes high in the same cycle that the number of pending sources goes from zero to non-zero. It stays high while at least one source is pending, and it falls in the same cycle that the last pending source drops out.
- R6: A cycle with `vec_req` high makes `vec_valid` high in the next cycle. In that cycle `vec_code` equals `VEC_BASE + k*VEC_STEP`, where k is the lowest index that was pending when the request was sampled. `vec_valid` is low in any cycle that does not follow a request.
- R7: A request made while `cpu_imask` equals 4'hF returns `vec_valid` low.
- R8: A request made while no source is pending returns `vec_valid` low.
- R9: An increment and a decrement strobe on the same source in the same cycle leave its enable count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | NUM_SRC | Interrupt level of each source |
| en_inc | input | NUM_SRC | One-cycle strobe: one more enable point now enables the source |
| en_dec | input | NUM_SRC | One-cycle strobe: one enable point no longer enables the source |
| vec_req | input | 1 | Vector fetch request |
| cpu_imask | input | 4 | CPU interrupt mask level; 4'hF blocks vector fetch |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| vec_valid | output | 1 | The vector returned for the previous cycle's request is valid |
| vec_code | output | VEC_W | Vector code of the lowest-index pending source |

## Verification
The assertions assume that `src_level`, the strobes, `vec_req` and `cpu_imask` are synchronous to `clk` and settle before each rising edge. They also assume that the strobes are only pulses whose net effect the block resolves, so an increment past the ceiling or a decrement below zero is legal input that the saturating count must absorb. The bench drives every input on the falling edge from a pseudo-random generator, which deliberately produces saturating strobe bursts, simultaneous increment and decrement, and masked requests. Because of this, the assertions on the count bounds and on the agreement between the pending count and the pending flags are exercised at their edges.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam logic [3:0] IMASK_BLOCK_ALL = 4'hF;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } cnt_step_e;

    function automatic cnt_step_e decode_step(input logic up, input logic down);
        if (up && !down)      return STEP_UP;
        else if (down && !up) return STEP_DOWN;
        else                  return STEP_HOLD;
    endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
    import irq_agg_pkg::*;
#(
    parameter int unsigned CNT_W = 2,
    parameter int unsigned MAX   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic en_inc,
    input  logic en_dec,
    output logic pending,
    output logic pend_rise,
    output logic pend_fall
);
    localparam logic [CNT_W-1:0] MAX_L    = CNT_W'(MAX);
    localparam bit               NEVER_ON = (MAX == 0);

    typedef struct packed {
        logic             asserted;
        logic [CNT_W-1:0] cnt;
        logic             pending;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (level != st_q.asserted) begin
            st_d.asserted = level;
        end
        unique case (decode_step(en_inc, en_dec))
            STEP_UP:   if (st_q.cnt < MAX_L) st_d.cnt = st_q.cnt + 1'b1;
            STEP_DOWN: if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - 1'b1;
            default:   st_d.cnt = st_q.cnt;
        endcase
        st_d.pending = st_d.asserted && !NEVER_ON && (st_d.cnt == MAX_L);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending   = st_q.pending;
    assign pend_rise = st_d.pending && !st_q.pending;
    assign pend_fall = !st_d.pending && st_q.pending;

    assert_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= MAX_L);

    assert_pend_has_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> $past(level));

    assert_both_strobes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_inc && en_dec) |=> $stable(st_q.cnt));

endmodule

// File: rtl/irq_pend_counter.sv
module irq_pend_counter #(
    parameter int unsigned NUM_SRC = 8,
    localparam int unsigned CW     = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] rise,
    input  logic [NUM_SRC-1:0] fall,
    input  logic [NUM_SRC-1:0] pend_vec,
    output logic               irq
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          irq;
    } ctr_t;

    ctr_t          c_d, c_q;
    logic [CW-1:0] n_up, n_dn;

    always_comb begin
        n_up = '0;
        n_dn = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            n_up = n_up + CW'(rise[i]);
            n_dn = n_dn + CW'(fall[i]);
        end
        c_d     = c_q;
        c_d.cnt = c_q.cnt + n_up - n_dn;
        c_d.irq = (c_d.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign irq = c_q.irq;

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.cnt <= CW'(NUM_SRC));

    assert_count_tracks_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(c_q.cnt) == $countones(pend_vec));

    assert_irq_follows_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|pend_vec));

endmodule

// File: rtl/irq_vec_picker.sv
module irq_vec_picker
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned VEC_W    = 12,
    parameter int unsigned VEC_BASE = 'h100,
    parameter int unsigned VEC_STEP = 'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_vec,
    input  logic               req,
    input  logic [3:0]         imask,
    output logic               valid,
    output logic [VEC_W-1:0]   code
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] code;
    } vec_t;

    vec_t             v_d, v_q;
    logic             found;
    logic [VEC_W-1:0] hit_code;

    always_comb begin
        found    = 1'b0;
        hit_code = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_vec[i]) begin
                found    = 1'b1;
                hit_code = VEC_W'(VEC_BASE + i * VEC_STEP);
            end
        end
        v_d       = v_q;
        v_d.valid = 1'b0;
        if (req && found && (imask != IMASK_BLOCK_ALL)) begin
            v_d.valid = 1'b1;
            v_d.code  = hit_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= '0;
        else        v_q <= v_d;
    end

    assign valid = v_q.valid;
    assign code  = v_q.code;

    assert_valid_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(req));

    assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ($past(imask) != IMASK_BLOCK_ALL));

    assert_valid_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(|pend_vec));

endmodule

// File: rtl/irq_pend_agg.sv
module irq_pend_agg #(
    parameter int unsigned NUM_SRC  = 8,
    parameter int unsigned CNT_W    = 2,
    parameter logic [NUM_SRC*CNT_W-1:0] EN_MAX =
        {2'd1, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1},
    parameter int unsigned VEC_W    = 12,
    parameter int unsigned VEC_BASE = 'h100,
    parameter int unsigned VEC_STEP = 'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic [NUM_SRC-1:0] en_inc,
    input  logic [NUM_SRC-1:0] en_dec,
    input  logic               vec_req,
    input  logic [3:0]         cpu_imask,
    output logic               cpu_irq,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_code
);
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] rise_vec;
    logic [NUM_SRC-1:0] fall_vec;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        irq_src_slot #(
            .CNT_W (CNT_W),
            .MAX   (int'(EN_MAX[g*CNT_W +: CNT_W]))
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (src_level[g]),
            .en_inc    (en_inc[g]),
            .en_dec    (en_dec[g]),
            .pending   (pend_vec[g]),
            .pend_rise (rise_vec[g]),
            .pend_fall (fall_vec[g])
        );
    end

    irq_pend_counter #(
        .NUM_SRC (NUM_SRC)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_vec),
        .fall     (fall_vec),
        .pend_vec (pend_vec),
        .irq      (cpu_irq)
    );

    irq_vec_picker #(
        .NUM_SRC  (NUM_SRC),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_vec (pend_vec),
        .req      (vec_req),
        .imask    (cpu_imask),
        .valid    (vec_valid),
        .code     (vec_code)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (!cpu_irq && !vec_valid));

endmodule

// File: tb/sim_irq_pend_agg.sv
module sim_irq_pend_agg;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_level = '0, en_inc = '0, en_dec = '0;
    logic          vec_req = 1'b0;
    logic [3:0]    cpu_imask = 4'h0;
    logic          cpu_irq, vec_valid;
    logic [11:0]   vec_code;

    int checks = 0, fails = 0;
    bit done = 0;
    int mx [N] = '{1, 2, 3, 0, 1, 2, 3, 1};
    int cnt [N];
    logic [N-1:0] lvl;
    logic [31:0] lf = 32'h1234_5678;

    always #4 clk = ~clk;

    irq_pend_agg #(.NUM_SRC(8), .CNT_W(2), .VEC_W(12), .VEC_BASE('h100), .VEC_STEP('h10)) u0 (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .en_inc(en_inc), .en_dec(en_dec),
        .vec_req(vec_req), .cpu_imask(cpu_imask), .cpu_irq(cpu_irq),
        .vec_valid(vec_valid), .vec_code(vec_code));

    function automatic bit pend(int i);
        return lvl[i] && mx[i] != 0 && cnt[i] == mx[i];
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(string tag, logic [N-1:0] lv, logic [N-1:0] inc, logic [N-1:0] dec,
                         logic rq, logic [3:0] im);
        int first_i;
        bit exp_v;
        src_level = lv; en_inc = inc; en_dec = dec; vec_req = rq; cpu_imask = im;
        first_i = -1;
        for (int i = N - 1; i >= 0; i--) if (pend(i)) first_i = i;
        exp_v = rq && im != 4'hF && first_i >= 0;
        @(posedge clk);
        lvl = lv;
        for (int i = 0; i < N; i++) begin
            if (inc[i] && !dec[i] && cnt[i] < mx[i]) cnt[i]++;
            else if (dec[i] && !inc[i] && cnt[i] > 0) cnt[i]--;
        end
        @(negedge clk);
        begin
            bit any;
            any = 0;
            for (int i = 0; i < N; i++) any |= pend(i);
            check(tag, "cpu_irq", int'(cpu_irq), int'(any));
        end
        check(tag, "vec_valid", int'(vec_valid), int'(exp_v));
        if (exp_v) check(tag, "vec_code", int'(vec_code), 'h100 + first_i * 'h10);
    endtask

    task automatic clear_all();
        for (int k = 0; k < 4; k++) cycle("R2", '0, '0, '1, 1'b1, 4'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=hung exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        lvl = '0;
        for (int i = 0; i < N; i++) cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "cpu_irq", int'(cpu_irq), 0);
        check("R1", "vec_valid", int'(vec_valid), 0);
        rst_n = 1'b1;
        // R8: request with nothing pending
        cycle("R8", '0, '0, '0, 1'b1, 4'h0);
        cycle("R8", '1, '0, '0, 1'b1, 4'h3);
        cycle("R8", '1, '0, '0, 1'b1, 4'h3);
        clear_all();

        // R2: per-source saturation at ceiling and zero, ceiling 0 never enabled
        for (int s = 0; s < N; s++) begin
            clear_all();
            for (int k = 0; k < 5; k++) cycle("R2", N'(1) << s, N'(1) << s, '0, 1'b1, 4'h0);
            cycle("R2", N'(1) << s, '0, N'(1) << s, 1'b1, 4'h0);
            cycle("R2", N'(1) << s, '0, '0, 1'b1, 4'h0);
            for (int k = 0; k < 5; k++) cycle("R2", N'(1) << s, '0, N'(1) << s, 1'b1, 4'h0);
            cycle("R2", N'(1) << s, N'(1) << s, '0, 1'b1, 4'h0);
        end

        // R9: simultaneous strobes hold the count
        clear_all();
        cycle("R9", 8'h01, 8'h01, 8'h00, 1'b1, 4'h0);
        for (int k = 0; k < 4; k++) cycle("R9", 8'h01, 8'h01, 8'h01, 1'b1, 4'h0);
        cycle("R9", 8'h01, 8'h00, 8'h01, 1'b1, 4'h0);
        cycle("R9", 8'h01, 8'h01, 8'h01, 1'b1, 4'h0);

        // R4: held levels change nothing; R7: mask 4'hF blocks
        cycle("R4", 8'h01, 8'h01, 8'h00, 1'b1, 4'h0);
        for (int k = 0; k < 4; k++) cycle("R4", 8'h01, 8'h00, 8'h00, 1'b1, 4'h0);
        cycle("R4", 8'h00, 8'h00, 8'h00, 1'b1, 4'h0);
        cycle("R4", 8'h00, 8'h00, 8'h00, 1'b1, 4'h0);
        cycle("R7", 8'h01, 8'h00, 8'h00, 1'b1, 4'hF);
        cycle("R7", 8'h01, 8'h00, 8'h00, 1'b1, 4'hF);
        cycle("R7", 8'h01, 8'h00, 8'h00, 1'b1, 4'hE);
        cycle("R6", 8'h01, 8'h00, 8'h00, 1'b0, 4'h0);

        // R3 R5 R6 R7: pseudo-random sweep
        for (int k = 0; k < 6000; k++) begin
            logic [N-1:0] lv, inc, dec;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            lv  = lf[7:0] | lf[15:8];
            inc = lf[23:16] & ~lf[31:24];
            dec = lf[31:24] & lf[11:4] & ~lf[19:12];
            cycle("R3/R5/R6", lv, inc, dec, lf[2] | lf[9], (lf[28:26] == 3'd0) ? 4'hF : lf[13:10]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule